// File: doc/BRIEF.md
# Multiplexed GPIO Port

This block is a parameterised digital I/O port. Each pin can be driven either by software-controlled registers or by an on-chip peripheral. Three per-pin registers configure and drive the port. A function-select register picks the output source for each pin. A direction register sets the output enable while a pin is under register control. A data register holds the value driven out.

The data register can be loaded by a direct write. It can also be changed bit by bit through write-only set, clear and invert addresses, so software can change single pins without a read-modify-write. A single register bus carries all writes. Reads on the same bus are combinational.

The pin input is always routed straight to the peripheral, whatever the pin's mode. A read of the data address returns one of two values for each pin, chosen by that pin's direction bit. For an output it returns the stored value. For an input it returns the live pin level, and this holds in peripheral mode too. Input qualification is done elsewhere, and `pinIn` is its already-filtered output.

Top module: `gpio_mux_port`

## Requirements
- R1: An asynchronous active-low reset (`rstN`) clears the function-select, direction and data registers to 0. After reset, reads of addresses 0, 1 and 2 with `pinIn` at 0 return 0.
- R2: While `rstN` is low, every bit of `pinOe` is 0, whatever the peripheral inputs are.
- R3: For a pin whose function-select bit is 0 (register control), `pinOut` equals that pin's data register bit and `pinOe` equals its direction bit (1 = output).
- R4: For a pin whose function-select bit is 1 (peripheral), `pinOut` follows `periphOut` and `pinOe` follows `periphOe` for that pin.
- R5: A bus write to address 2 loads the data register with `busWrData` at the clock edge.
- R6: A bus write to address 3 sets each data bit whose `busWrData` bit is 1. Bits written with 0 keep their value.
- R7: A bus write to address 4 clears each data bit whose `busWrData` bit is 1. Bits written with 0 keep their value.
- R8: A bus write to address 5 inverts each data bit whose `busWrData` bit is 1. Bits written with 0 keep their value.
- R9: A read of address 2 returns the data register bit for pins whose direction bit is 1. For pins whose direction bit is 0 it returns the `pinIn` bit, in either function mode.
- R10: `periphIn` equals `pinIn` at all times, in every mode and direction.
- R11: A read of address 0 returns the function-select register and a read of address 1 returns the direction register. Reads of addresses 3 to 7 return 0.
- R12: `busRdData` is combinational. A read of a register in the same cycle as a write to it returns the value held before that clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrEn | input | 1 | Register write strobe |
| busAddr | input | 3 | Register address for writes and reads |
| busWrData | input | NUM_PINS | Write data or bit mask |
| busRdData | output | NUM_PINS | Combinational read data |
| periphOut | input | NUM_PINS | Peripheral output values |
| periphOe | input | NUM_PINS | Peripheral output enables |
| periphIn | output | NUM_PINS | Pin levels delivered to the peripheral |
| pinOut | output | NUM_PINS | Value driven to the pads |
| pinOe | output | NUM_PINS | Pad output enables (1 = drive) |
| pinIn | input | NUM_PINS | Qualified pin levels |

## Verification
A register write and a read of that same register can fall in the same cycle, because one bus address serves both and the read path is combinational. The bench provokes this by setting up a data write and sampling `busRdData` before the capturing edge. It expects the old contents there and the new contents one cycle later. Mixed-mode cases cover a second overlap: peripheral-driven pins sit beside register-driven pins in one word, and the expected `pinOut`, `pinOe` and read values are composed bit by bit from the select and direction masks.

// File: rtl/gpio_mux_pkg.sv
package gpio_mux_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_FSEL = 3'd0,
    ADDR_DIR  = 3'd1,
    ADDR_DATA = 3'd2,
    ADDR_SET  = 3'd3,
    ADDR_CLR  = 3'd4,
    ADDR_INV  = 3'd5
  } regAddr_e;

  typedef enum logic [1:0] {
    RD_ZERO = 2'd0,
    RD_FSEL = 2'd1,
    RD_DIR  = 2'd2,
    RD_DATA = 2'd3
  } rdSel_e;

  typedef struct packed {
    logic   fselWe;
    logic   dirWe;
    logic   dataWe;
    logic   setWe;
    logic   clrWe;
    logic   invWe;
    rdSel_e rdSel;
  } ctrlStrobes_t;
endpackage

// File: rtl/gpio_mux_ctrl.sv
module gpio_mux_ctrl
  import gpio_mux_pkg::*;
(
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  output ctrlStrobes_t      strobes
);
  always_comb begin
    strobes        = '0;
    strobes.rdSel  = RD_ZERO;
    case (busAddr)
      ADDR_FSEL: begin strobes.fselWe = busWrEn; strobes.rdSel = RD_FSEL; end
      ADDR_DIR:  begin strobes.dirWe  = busWrEn; strobes.rdSel = RD_DIR;  end
      ADDR_DATA: begin strobes.dataWe = busWrEn; strobes.rdSel = RD_DATA; end
      ADDR_SET:  strobes.setWe = busWrEn;
      ADDR_CLR:  strobes.clrWe = busWrEn;
      ADDR_INV:  strobes.invWe = busWrEn;
      default:   ;
    endcase
  end
endmodule

// File: rtl/gpio_mux_dp.sv
module gpio_mux_dp
  import gpio_mux_pkg::*;
#(
  parameter int NUM_PINS = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobes_t        strobes,
  input  logic [NUM_PINS-1:0] busWrData,
  output logic [NUM_PINS-1:0] busRdData,
  input  logic [NUM_PINS-1:0] periphOut,
  input  logic [NUM_PINS-1:0] periphOe,
  output logic [NUM_PINS-1:0] periphIn,
  output logic [NUM_PINS-1:0] pinOut,
  output logic [NUM_PINS-1:0] pinOe,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [NUM_PINS-1:0] fselQ,
  output logic [NUM_PINS-1:0] dirQ,
  output logic [NUM_PINS-1:0] dataQ
);
  logic [NUM_PINS-1:0] dataNext;
  logic [NUM_PINS-1:0] dataView;

  // Bit operations are applied after a direct load so they take precedence.
  always_comb begin
    dataNext = dataQ;
    if (strobes.dataWe) dataNext = busWrData;
    if (strobes.setWe)  dataNext = dataNext | busWrData;
    if (strobes.clrWe)  dataNext = dataNext & ~busWrData;
    if (strobes.invWe)  dataNext = dataNext ^ busWrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fselQ <= '0;
      dirQ  <= '0;
      dataQ <= '0;
    end else begin
      if (strobes.fselWe) fselQ <= busWrData;
      if (strobes.dirWe)  dirQ  <= busWrData;
      dataQ <= dataNext;
    end
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    assign pinOut[p]   = fselQ[p] ? periphOut[p] : dataQ[p];
    assign pinOe[p]    = rstN & (fselQ[p] ? periphOe[p] : dirQ[p]);
    assign dataView[p] = dirQ[p] ? dataQ[p] : pinIn[p];
    assign periphIn[p] = pinIn[p];
  end

  always_comb begin
    case (strobes.rdSel)
      RD_FSEL: busRdData = fselQ;
      RD_DIR:  busRdData = dirQ;
      RD_DATA: busRdData = dataView;
      default: busRdData = '0;
    endcase
  end
endmodule

// File: rtl/gpio_mux_port.sv
module gpio_mux_port
  import gpio_mux_pkg::*;
#(
  parameter int NUM_PINS = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busWrEn,
  input  logic [2:0]          busAddr,
  input  logic [NUM_PINS-1:0] busWrData,
  output logic [NUM_PINS-1:0] busRdData,
  input  logic [NUM_PINS-1:0] periphOut,
  input  logic [NUM_PINS-1:0] periphOe,
  output logic [NUM_PINS-1:0] periphIn,
  output logic [NUM_PINS-1:0] pinOut,
  output logic [NUM_PINS-1:0] pinOe,
  input  logic [NUM_PINS-1:0] pinIn
);
  ctrlStrobes_t        strobes;
  logic [NUM_PINS-1:0] fselQ;
  logic [NUM_PINS-1:0] dirQ;
  logic [NUM_PINS-1:0] dataQ;

  gpio_mux_ctrl ctrl_i (
    .busWrEn (busWrEn),
    .busAddr (busAddr),
    .strobes (strobes)
  );

  gpio_mux_dp #(.NUM_PINS(NUM_PINS)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .busWrData (busWrData),
    .busRdData (busRdData),
    .periphOut (periphOut),
    .periphOe  (periphOe),
    .periphIn  (periphIn),
    .pinOut    (pinOut),
    .pinOe     (pinOe),
    .pinIn     (pinIn),
    .fselQ     (fselQ),
    .dirQ      (dirQ),
    .dataQ     (dataQ)
  );
endmodule

// File: rtl/gpio_mux_port_chk.sv
module gpio_mux_port_chk #(
  parameter int NUM_PINS = 16
) (
  input logic                clk,
  input logic                rstN,
  input logic                busWrEn,
  input logic [2:0]          busAddr,
  input logic [NUM_PINS-1:0] busWrData,
  input logic [NUM_PINS-1:0] periphOut,
  input logic [NUM_PINS-1:0] periphOe,
  input logic [NUM_PINS-1:0] pinOut,
  input logic [NUM_PINS-1:0] pinOe,
  input logic [NUM_PINS-1:0] fselQ,
  input logic [NUM_PINS-1:0] dirQ,
  input logic [NUM_PINS-1:0] dataQ
);
  always_comb begin
    if (!rstN) a_r2_oe_off_in_reset: assert (pinOe == '0);
  end

  a_r5_direct_load: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == 3'd2) |=> dataQ == $past(busWrData));

  a_r6_set_bits: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == 3'd3) |=> dataQ == ($past(dataQ) | $past(busWrData)));

  a_r7_clear_bits: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == 3'd4) |=> dataQ == ($past(dataQ) & ~$past(busWrData)));

  a_r8_invert_bits: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == 3'd5) |=> dataQ == ($past(dataQ) ^ $past(busWrData)));

  a_r3_reg_pins_follow_regs: assert property (@(posedge clk) disable iff (!rstN)
    (((pinOut ^ dataQ) | (pinOe ^ dirQ)) & ~fselQ) == '0);

  a_r4_periph_pins_follow_periph: assert property (@(posedge clk) disable iff (!rstN)
    (((pinOut ^ periphOut) | (pinOe ^ periphOe)) & fselQ) == '0);

  a_r12_state_holds_without_write: assert property (@(posedge clk) disable iff (!rstN)
    !busWrEn |=> ($stable(dataQ) && $stable(dirQ) && $stable(fselQ)));
endmodule

bind gpio_mux_port gpio_mux_port_chk #(.NUM_PINS(NUM_PINS)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .busWrEn   (busWrEn),
  .busAddr   (busAddr),
  .busWrData (busWrData),
  .periphOut (periphOut),
  .periphOe  (periphOe),
  .pinOut    (pinOut),
  .pinOe     (pinOe),
  .fselQ     (fselQ),
  .dirQ      (dirQ),
  .dataQ     (dataQ)
);

// File: tb/gpio_mux_port_tb_top.sv
`timescale 1ns/1ps
module gpio_mux_port_tb_top;
  localparam int N = 16;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         busWrEn = 1'b0;
  logic [2:0]   busAddr = 3'd0;
  logic [N-1:0] busWrData = '0;
  logic [N-1:0] busRdData;
  logic [N-1:0] periphOut = '0;
  logic [N-1:0] periphOe = '0;
  logic [N-1:0] periphIn;
  logic [N-1:0] pinOut;
  logic [N-1:0] pinOe;
  logic [N-1:0] pinIn = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  gpio_mux_port #(.NUM_PINS(N)) dut_i (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .periphOut(periphOut),
    .periphOe(periphOe), .periphIn(periphIn), .pinOut(pinOut),
    .pinOe(pinOe), .pinIn(pinIn)
  );

  task automatic check(input string tag, input logic [N-1:0] got, input logic [N-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic busWrite(input logic [2:0] addr, input logic [N-1:0] data);
    @(negedge clk);
    busAddr = addr; busWrData = data; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
    #1;
  endtask

  task automatic busRead(input logic [2:0] addr, output logic [N-1:0] data);
    busAddr = addr;
    #1;
    data = busRdData;
  endtask

  task automatic testReset();
    logic [N-1:0] rd;
    busWrite(3'd0, 16'hFFFF);
    periphOe = 16'hFFFF;
    #1;
    check("R4 oe follows periph before reset", pinOe, 16'hFFFF);
    rstN = 1'b0;
    #1;
    check("R2 oe forced off in reset", pinOe, 16'h0000);
    pinIn = '0;
    @(negedge clk);
    rstN = 1'b1;
    #1;
    busRead(3'd0, rd); check("R1 select reg after reset", rd, 16'h0000);
    busRead(3'd1, rd); check("R1 direction reg after reset", rd, 16'h0000);
    busRead(3'd2, rd); check("R1 data read after reset", rd, 16'h0000);
    periphOe = '0;
  endtask

  task automatic testRegMode();
    busWrite(3'd1, 16'h00FF);
    busWrite(3'd2, 16'hA5A5);
    check("R3 pinOut from data", pinOut, 16'hA5A5);
    check("R3 pinOe from direction", pinOe, 16'h00FF);
  endtask

  task automatic testPeriphMode();
    logic [N-1:0] rd;
    periphOut = 16'h1234; periphOe = 16'hFFFF;
    busWrite(3'd0, 16'h0F0F);
    check("R4 mixed pinOut", pinOut, 16'hA2A4);
    check("R4 mixed pinOe", pinOe, 16'h0FFF);
    busRead(3'd0, rd); check("R11 select readback", rd, 16'h0F0F);
    busRead(3'd1, rd); check("R11 direction readback", rd, 16'h00FF);
    busWrite(3'd0, 16'h0000);
    periphOe = '0;
  endtask

  task automatic testBitOps();
    logic [N-1:0] rd;
    busWrite(3'd1, 16'hFFFF);
    busWrite(3'd2, 16'h0000);
    busWrite(3'd3, 16'h00F0);
    busRead(3'd2, rd); check("R6 set bits", rd, 16'h00F0);
    busWrite(3'd4, 16'h0030);
    busRead(3'd2, rd); check("R7 clear bits", rd, 16'h00C0);
    busWrite(3'd5, 16'h0FF0);
    busRead(3'd2, rd); check("R8 invert bits", rd, 16'h0F30);
    busWrite(3'd2, 16'h5A5A);
    busRead(3'd2, rd); check("R5 direct load", rd, 16'h5A5A);
    busWrite(3'd2, 16'h0F30);
  endtask

  task automatic testReadMix();
    logic [N-1:0] rd;
    busWrite(3'd1, 16'h00FF);
    pinIn = 16'hABCD;
    busRead(3'd2, rd); check("R9 register mode mixed read", rd, 16'hAB30);
    busWrite(3'd0, 16'hFFFF);
    pinIn = 16'h1357;
    busRead(3'd2, rd); check("R9 periph mode input read", rd, 16'h1330);
    check("R10 periphIn in periph mode", periphIn, 16'h1357);
    busWrite(3'd0, 16'h0000);
    busWrite(3'd1, 16'hFFFF);
    pinIn = 16'hC3C3;
    #1;
    check("R10 periphIn in register output mode", periphIn, 16'hC3C3);
    busRead(3'd3, rd); check("R11 set address reads zero", rd, 16'h0000);
    busRead(3'd7, rd); check("R11 unused address reads zero", rd, 16'h0000);
  endtask

  task automatic testReadDuringWrite();
    logic [N-1:0] rd;
    @(negedge clk);
    busAddr = 3'd2; busWrData = 16'hBEEF; busWrEn = 1'b1;
    #1;
    check("R12 read in write cycle gives old", busRdData, 16'h0F30);
    @(negedge clk);
    busWrEn = 1'b0;
    #1;
    busRead(3'd2, rd); check("R12 read after write gives new", rd, 16'hBEEF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testRegMode();
    testPeriphMode();
    testBitOps();
    testReadMix();
    testReadDuringWrite();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule